// File: doc/BRIEF.md
# Function Unit Operand and Result Wrapper

This block sits around a two-input function unit and handles everything on its edges. A 16-bit control word arrives every cycle. Each of the two operand registers takes a new value from one of four places: the network port for that side, the unit's own accumulator entry, the link entry of a chained neighbour, or its own current contents. The opcode travels one stage alongside the captured operands, and the unit's result is written into a 16-entry result file one cycle after the operands were captured, unless the opcode is zero.

The result file is a small distributed store. One registered read port serves the network, addressed by the current control word, even while the unit is idle. Entry 14 acts as an accumulator and entry 15 as a link toward the next unit in a chain; both are visible at all times on dedicated taps and are still ordinary storage for the read and write addresses. Chaining a multiplier's link tap into this block's link input, with the accumulator fed back on the other side, builds a multiply-accumulate that needs only two network transports per step. There is no interlock and no forwarding into the operand registers; the program spaces dependent operations.

Top module: `opw_top`

## Requirements
- R1: The control word fields are: bits [1:0] left input mode, [3:2] right input mode, [7:4] result write address, [11:8] result read address, [15:12] opcode.
- R2: Mode code 00 (net) loads the side's network input into that operand register at the next clock edge.
- R3: Mode code 01 (acc) loads the value held in result entry 14 just before the edge; a write to entry 14 at that same edge is not seen.
- R4: Mode code 10 (link) loads the neighbour link input `chain_in` into that operand register.
- R5: Mode code 11 (hold) leaves that operand register unchanged.
- R6: A control word with mode 11 on both sides drives `bad_ctrl` high in the same cycle and leaves both operand registers unchanged; otherwise `bad_ctrl` is low.
- R7: The opcode of a control word appears on `fu_opcode` after the same clock edge that captures that word's operands.
- R8: When the opcode is nonzero, `fu_result` is written to the word's write address at the edge that ends the cycle after the capture; opcode 0000 writes nothing.
- R9: `net_rdata` shows, one edge after a control word, the entry at its read address, with a write at that same edge already applied.
- R10: `acc_tap` always shows entry 14 and `link_out` always shows entry 15, independent of the read address; both entries can also be written and read through the normal ports.
- R11: While `rst_n` is low, both operand registers, `fu_opcode`, `net_rdata`, and every result entry (so both taps) are zero.
- R12: With the left side in link mode, the right in acc mode, write address 14 and a nonzero add opcode, each step adds `chain_in` to entry 14, given one idle cycle between steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 16 | Per-cycle control word |
| net_left | input | DW | Network operand for the left input |
| net_right | input | DW | Network operand for the right input |
| chain_in | input | DW | Link entry of the neighbour unit |
| fu_result | input | DW | Result from the function unit |
| fu_left | output | DW | Left operand register |
| fu_right | output | DW | Right operand register |
| fu_opcode | output | 4 | Opcode aligned with the operand registers |
| net_rdata | output | DW | Registered network read data |
| acc_tap | output | DW | Accumulator entry (14) |
| link_out | output | DW | Link entry (15), to the next unit |
| bad_ctrl | output | 1 | Both inputs requested hold |

## Verification
The checks assume that `fu_result` is a pure function of the operand registers and opcode, settled within the cycle, and that `chain_in` is stable around each edge. The bench meets this with a combinational add/multiply model and by changing every input only on the falling clock edge. Dependent accumulator steps are always separated by an idle cycle, as the missing forwarding path demands, and the double-hold word is applied only once and on purpose to exercise the flag.

// File: rtl/opw_pkg.sv
package opw_pkg;
  localparam int unsigned CW_W    = 16;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned DEPTH   = 1 << ADDR_W;
  localparam int unsigned ACC_IDX = DEPTH - 2;
  localparam int unsigned LNK_IDX = DEPTH - 1;

  typedef enum logic [1:0] {
    MODE_NET  = 2'b00,
    MODE_ACC  = 2'b01,
    MODE_LINK = 2'b10,
    MODE_HOLD = 2'b11
  } in_mode_e;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] raddr;
    logic [ADDR_W-1:0] waddr;
    in_mode_e          rmode;
    in_mode_e          lmode;
  } ctrl_s;

  localparam logic [OP_W-1:0] OP_NOP = '0;
endpackage

// File: rtl/opw_input_reg.sv
module opw_input_reg
  import opw_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  in_mode_e      mode,
  input  logic [DW-1:0] net_d,
  input  logic [DW-1:0] acc_d,
  input  logic [DW-1:0] link_d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_nxt;
  logic          q_en;

  always_comb begin
    q_en  = 1'b1;
    q_nxt = q;
    unique case (mode)
      MODE_NET:  q_nxt = net_d;
      MODE_ACC:  q_nxt = acc_d;
      MODE_LINK: q_nxt = link_d;
      default:   q_en  = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end
endmodule

// File: rtl/opw_ctrl_stage.sv
module opw_ctrl_stage
  import opw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_d,
  input  logic [ADDR_W-1:0] wa_d,
  output logic [OP_W-1:0]   op_q,
  output logic [ADDR_W-1:0] wa_q,
  output logic              we
);
  logic [OP_W-1:0]   op_nxt;
  logic [ADDR_W-1:0] wa_nxt;

  always_comb begin
    op_nxt = op_d;
    wa_nxt = wa_d;
    we     = (op_q != OP_NOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_NOP;
      wa_q <= '0;
    end else begin
      op_q <= op_nxt;
      wa_q <= wa_nxt;
    end
  end
endmodule

// File: rtl/opw_result_file.sv
module opw_result_file
  import opw_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DW-1:0]     rdata_q,
  output logic [DW-1:0]     acc_o,
  output logic [DW-1:0]     lnk_o
);
  logic [DW-1:0] ent [DEPTH];
  logic [DW-1:0] rd_nxt;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (waddr == ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent[i] <= '0;
      else if (ent_en) ent[i] <= wdata;
    end
  end

  always_comb begin
    if (we && (waddr == raddr)) rd_nxt = wdata;
    else                        rd_nxt = ent[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_nxt;
  end

  assign acc_o = ent[ACC_IDX];
  assign lnk_o = ent[LNK_IDX];
endmodule

// File: rtl/opw_top.sv
module opw_top
  import opw_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW_W-1:0]   ctrl_word,
  input  logic [DW-1:0]     net_left,
  input  logic [DW-1:0]     net_right,
  input  logic [DW-1:0]     chain_in,
  input  logic [DW-1:0]     fu_result,
  output logic [DW-1:0]     fu_left,
  output logic [DW-1:0]     fu_right,
  output logic [OP_W-1:0]   fu_opcode,
  output logic [DW-1:0]     net_rdata,
  output logic [DW-1:0]     acc_tap,
  output logic [DW-1:0]     link_out,
  output logic              bad_ctrl
);
  ctrl_s             cw;
  in_mode_e          side_mode [2];
  logic [DW-1:0]     side_net  [2];
  logic [DW-1:0]     side_q    [2];
  logic [ADDR_W-1:0] wa_q;
  logic              we;

  assign cw           = ctrl_s'(ctrl_word);
  assign side_mode[0] = cw.lmode;
  assign side_mode[1] = cw.rmode;
  assign side_net[0]  = net_left;
  assign side_net[1]  = net_right;
  assign bad_ctrl     = (cw.lmode == MODE_HOLD) && (cw.rmode == MODE_HOLD);

  for (genvar s = 0; s < 2; s++) begin : g_side
    opw_input_reg #(.DW(DW)) u_in (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode   (side_mode[s]),
      .net_d  (side_net[s]),
      .acc_d  (acc_tap),
      .link_d (chain_in),
      .q      (side_q[s])
    );
  end

  assign fu_left  = side_q[0];
  assign fu_right = side_q[1];

  opw_ctrl_stage u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .op_d  (cw.op),
    .wa_d  (cw.waddr),
    .op_q  (fu_opcode),
    .wa_q  (wa_q),
    .we    (we)
  );

  opw_result_file #(.DW(DW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (we),
    .waddr   (wa_q),
    .wdata   (fu_result),
    .raddr   (cw.raddr),
    .rdata_q (net_rdata),
    .acc_o   (acc_tap),
    .lnk_o   (link_out)
  );
endmodule

// File: rtl/opw_checker.sv
module opw_checker
  import opw_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CW_W-1:0]   ctrl_word,
  input logic [DW-1:0]     net_left,
  input logic [DW-1:0]     chain_in,
  input logic [DW-1:0]     fu_result,
  input logic [DW-1:0]     fu_left,
  input logic [DW-1:0]     fu_right,
  input logic [OP_W-1:0]   fu_opcode,
  input logic [DW-1:0]     net_rdata,
  input logic [DW-1:0]     acc_tap,
  input logic              bad_ctrl,
  input logic [ADDR_W-1:0] wa_q
);
  AST_NET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[1:0] == 2'b00) |=> (fu_left == $past(net_left))); // R2
  AST_ACC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[3:2] == 2'b01) |=> (fu_right == $past(acc_tap))); // R3
  AST_LINK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[1:0] == 2'b10) |=> (fu_left == $past(chain_in))); // R4
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[3:2] == 2'b11) |=> $stable(fu_right)); // R5
  AST_BAD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_ctrl |=> ($stable(fu_left) && $stable(fu_right))); // R6
  AST_OP_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fu_opcode == $past(ctrl_word[15:12]))); // R7
  AST_NOP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((fu_opcode == OP_NOP) && (wa_q == ADDR_W'(ACC_IDX))) |=> $stable(acc_tap)); // R8
  AST_ACC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((fu_opcode != OP_NOP) && (wa_q == ADDR_W'(ACC_IDX))) |=> (acc_tap == $past(fu_result))); // R10
  AST_WR_BEFORE_RD: assert property (@(posedge clk) disable iff (!rst_n)
    ((fu_opcode != OP_NOP) && (wa_q == ctrl_word[11:8])) |=> (net_rdata == $past(fu_result))); // R9
  always_comb begin
    if (!rst_n) begin
      AST_RESET_ZERO: assert (acc_tap == '0 || $isunknown(acc_tap)); // R11
    end
  end
endmodule

bind opw_top opw_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_word (ctrl_word),
  .net_left  (net_left),
  .chain_in  (chain_in),
  .fu_result (fu_result),
  .fu_left   (fu_left),
  .fu_right  (fu_right),
  .fu_opcode (fu_opcode),
  .net_rdata (net_rdata),
  .acc_tap   (acc_tap),
  .bad_ctrl  (bad_ctrl),
  .wa_q      (wa_q)
);

// File: tb/sim_opw_top.sv
module sim_opw_top;
  localparam int DW = 16;
  localparam logic [1:0] NET = 2'b00, ACC = 2'b01, LNK = 2'b10, HLD = 2'b11;
  localparam logic [3:0] NOP = 4'd0, ADD = 4'd1, MUL = 4'd2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [15:0]   ctrl_word;
  logic [DW-1:0] net_left, net_right, chain_in, fu_result;
  logic [DW-1:0] fu_left, fu_right, net_rdata, acc_tap, link_out;
  logic [3:0]    fu_opcode;
  logic          bad_ctrl;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  opw_top #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
    .net_left(net_left), .net_right(net_right), .chain_in(chain_in),
    .fu_result(fu_result), .fu_left(fu_left), .fu_right(fu_right),
    .fu_opcode(fu_opcode), .net_rdata(net_rdata), .acc_tap(acc_tap),
    .link_out(link_out), .bad_ctrl(bad_ctrl)
  );

  // function unit model: add or multiply
  always_comb begin
    if (fu_opcode == MUL) fu_result = DW'(fu_left * fu_right);
    else                  fu_result = DW'(fu_left + fu_right);
  end

  function automatic logic [15:0] mk(input logic [1:0] lm, input logic [1:0] rm,
                                     input logic [3:0] wa, input logic [3:0] ra,
                                     input logic [3:0] op);
    return {op, ra, wa, rm, lm};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic cyc(input logic [15:0] cw, input logic [DW-1:0] nl,
                     input logic [DW-1:0] nr, input logic [DW-1:0] ch);
    ctrl_word = cw; net_left = nl; net_right = nr; chain_in = ch;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    ctrl_word = mk(NET, NET, 4'd0, 4'd0, ADD);
    net_left = 16'd9; net_right = 16'd9; chain_in = 16'd9;
    repeat (3) @(negedge clk);
    chk("R11", "fu_left", fu_left, 0);
    chk("R11", "fu_right", fu_right, 0);
    chk("R11", "fu_opcode", fu_opcode, 0);
    chk("R11", "net_rdata", net_rdata, 0);
    chk("R11", "acc_tap", acc_tap, 0);
    chk("R11", "link_out", link_out, 0);
    rst_n = 1'b1;
    cyc(mk(NET, NET, 0, 0, NOP), 0, 0, 0);
  endtask

  task automatic t_net_write;
    cyc(mk(NET, NET, 4'd3, 4'd0, ADD), 16'd5, 16'd7, 0);
    chk("R2", "fu_left", fu_left, 5);
    chk("R2", "fu_right", fu_right, 7);
    chk("R7", "fu_opcode", fu_opcode, ADD);
    cyc(mk(NET, NET, 4'd0, 4'd3, NOP), 0, 0, 0);
    chk("R9", "forwarded read", net_rdata, 12);
    cyc(mk(NET, NET, 4'd0, 4'd3, NOP), 0, 0, 0);
    chk("R8", "stored entry 3", net_rdata, 12);
    cyc(mk(NET, NET, 4'd9, 4'd0, MUL), 16'd6, 16'd7, 0);
    cyc(mk(NET, NET, 4'd0, 4'd0, NOP), 0, 0, 0);
    cyc(mk(NET, NET, 4'd0, 4'd9, NOP), 0, 0, 0);
    chk("R1", "field layout, entry 9", net_rdata, 42);
  endtask

  task automatic t_nop;
    cyc(mk(NET, NET, 4'd3, 4'd0, NOP), 16'd100, 16'd1, 0);
    cyc(mk(NET, NET, 4'd3, 4'd3, NOP), 0, 0, 0);
    chk("R8", "nop leaves entry 3", net_rdata, 12);
  endtask

  task automatic t_hold;
    cyc(mk(NET, NET, 0, 0, NOP), 16'd11, 16'd22, 0);
    cyc(mk(HLD, NET, 0, 0, NOP), 16'd99, 16'd44, 0);
    chk("R5", "left held", fu_left, 11);
    chk("R5", "right loaded", fu_right, 44);
    cyc(mk(NET, HLD, 0, 0, NOP), 16'd55, 16'd66, 0);
    chk("R5", "right held", fu_right, 44);
  endtask

  task automatic t_bad;
    ctrl_word = mk(HLD, HLD, 0, 0, NOP); net_left = 16'd1; net_right = 16'd2;
    #2;
    chk("R6", "bad_ctrl high", bad_ctrl, 1);
    @(negedge clk);
    chk("R6", "left frozen", fu_left, 55);
    chk("R6", "right frozen", fu_right, 44);
    ctrl_word = mk(HLD, NET, 0, 0, NOP);
    #2;
    chk("R6", "bad_ctrl low", bad_ctrl, 0);
    @(negedge clk);
  endtask

  task automatic t_taps;
    cyc(mk(NET, NET, 4'd14, 4'd0, ADD), 16'd20, 16'd5, 0);
    cyc(mk(NET, NET, 4'd15, 4'd0, MUL), 16'd3, 16'd4, 0);
    chk("R10", "acc_tap", acc_tap, 25);
    cyc(mk(NET, NET, 4'd0, 4'd15, NOP), 0, 0, 0);
    chk("R10", "link_out", link_out, 12);
    chk("R10", "read entry 15", net_rdata, 12);
    cyc(mk(NET, NET, 4'd0, 4'd14, NOP), 0, 0, 0);
    chk("R10", "read entry 14", net_rdata, 25);
    cyc(mk(NET, NET, 4'd0, 4'd2, NOP), 0, 0, 0);
    chk("R10", "acc_tap independent of raddr", acc_tap, 25);
  endtask

  task automatic t_acc_link;
    cyc(mk(NET, NET, 4'd14, 4'd0, ADD), 16'd1, 16'd2, 0);
    cyc(mk(ACC, LNK, 0, 0, NOP), 0, 0, 16'd33);
    chk("R3", "acc mode sees old entry 14", fu_left, 25);
    chk("R4", "link mode", fu_right, 33);
    chk("R8", "entry 14 written", acc_tap, 3);
    cyc(mk(ACC, NET, 0, 0, NOP), 0, 16'd8, 0);
    chk("R3", "acc mode new value", fu_left, 3);
  endtask

  task automatic t_mac;
    logic [DW-1:0] a;
    cyc(mk(NET, NET, 4'd14, 4'd0, ADD), 16'd10, 16'd0, 0);
    cyc(mk(NET, NET, 0, 0, NOP), 0, 0, 0);
    a = 16'd10;
    for (int k = 0; k < 3; k++) begin
      logic [DW-1:0] p;
      p = DW'((k + 2) * (k + 3));
      cyc(mk(LNK, ACC, 4'd14, 4'd0, ADD), 0, 0, p);
      cyc(mk(NET, NET, 0, 0, NOP), 0, 0, 0);
      a = a + p;
      chk("R12", "accumulated", acc_tap, a);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_net_write();
    t_nop();
    t_hold();
    t_bad();
    t_taps();
    t_acc_link();
    t_mac();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule